// File: doc/BRIEF.md
# Packed SIMD Saturating Arithmetic Unit

This block is a 64-bit packed arithmetic and logic unit. Each operand is treated as a set of independent elements rather than a single integer: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane, chosen per operation by a lane-size input. Lane-wise add and subtract run in one of three modes. Wraparound keeps the low bits. Signed saturation clamps each lane to its own two's-complement limits. Unsigned saturation clamps each lane to all-ones or zero. The bitwise operations AND, OR, XOR and AND-with-inverted-B act on the whole 64-bit word.

The carry chain is cut at every lane boundary chosen by the lane size. Each lane decides on its own whether it overflowed. The result is captured in one output register together with a valid flag, so a result appears one clock after the operation is presented. There is no back-pressure.

Top module: `simd_alu`

## Requirements
- R1: With wraparound mode (mode code 0 or 3), add (op code 0) keeps the low bits of each lane. No carry passes from one lane into the next. Lane size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit, and lane k occupies bits [k*w +: w].
- R2: With wraparound mode, subtract (op code 1) gives a minus b modulo 2^w in each lane, and no borrow crosses a lane boundary.
- R3: With the 64-bit lane size, add and subtract carry across the full word, and any carry out of bit 63 is dropped.
- R4: Signed saturating add (mode code 1) on 8-bit or 16-bit lanes clamps a lane that overflows upward to its signed maximum (0x7F, 0x7FFF) and a lane that overflows downward to its signed minimum (0x80, 0x8000). A sum of two non-negative lanes never reads negative.
- R5: Signed saturating subtract on 8-bit or 16-bit lanes clamps to the same signed limits, each lane on its own.
- R6: Unsigned saturating add (mode code 2) on 8-bit or 16-bit lanes clamps an overflowing lane to all ones, so no lane result is below that lane of a.
- R7: Unsigned saturating subtract on 8-bit or 16-bit lanes clamps an underflowing lane to zero.
- R8: A saturating mode requested with 32-bit or 64-bit lanes behaves exactly as wraparound.
- R9: Op codes 2 (a AND b), 3 (a OR b), 4 (a XOR b) and 5 (a AND NOT b) act on all 64 bits regardless of lane size and mode. Op codes 6 and 7 give zero.
- R10: out_valid_o equals in_valid_i of the previous clock, and result_o holds the value computed one clock after the last accepted operation. result_o does not change while in_valid_i is low. After reset both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (see R1, R2, R9) |
| mode_i | input | 2 | Arithmetic mode: 0/3 wrap, 1 signed saturate, 2 unsigned saturate |
| size_i | input | 2 | Lane size code: 0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| out_valid_o | output | 1 | Result valid, one cycle after in_valid_i |
| result_o | output | 64 | Registered packed result |

## Verification
Every result is due exactly one clock after its operands are accepted, with out_valid_o rising on that same edge. Idle cycles in between must leave result_o unchanged. The bench drives on the falling edge. On each falling edge, before it applies new inputs, it compares both outputs against a behavioural lane-by-lane model evaluated for the operation applied one edge earlier. In this way each comparison falls on the cycle its result is due and a late or early update shows up at once. Directed vectors cover the lane-boundary carries, the clamp limits and the fall-back of wide lanes. A random stream then mixes all ops, modes and sizes with idle gaps.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_ANDN = 3'd5
    } simd_op_e;

    typedef enum logic [1:0] {
        MD_WRAP = 2'd0,
        MD_SSAT = 2'd1,
        MD_USAT = 2'd2
    } simd_mode_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } simd_size_e;

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             cin_i,
    output logic [SEG_W-1:0] sum_o,
    output logic             cout_o,
    output logic             cmsb_o
);
    logic [SEG_W:0] total;

    always_comb begin
        total  = {1'b0, a_i} + {1'b0, b_i} + {{SEG_W{1'b0}}, cin_i};
        sum_o  = total[SEG_W-1:0];
        cout_o = total[SEG_W];
        // carry that entered the top bit of this segment
        cmsb_o = total[SEG_W-1] ^ a_i[SEG_W-1] ^ b_i[SEG_W-1];
    end
endmodule

// File: rtl/simd_seg_clamp.sv
module simd_seg_clamp #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] sum_i,
    input  logic             clamp_en_i,
    input  logic             clamp_hi_i,
    input  logic             signed_i,
    input  logic             is_top_i,
    output logic [SEG_W-1:0] res_o
);
    localparam logic [SEG_W-1:0] ONES   = '1;
    localparam logic [SEG_W-1:0] ZEROS  = '0;
    localparam logic [SEG_W-1:0] S_MAX  = {1'b0, {(SEG_W-1){1'b1}}};
    localparam logic [SEG_W-1:0] S_MIN  = {1'b1, {(SEG_W-1){1'b0}}};

    always_comb begin
        if (!clamp_en_i) begin
            res_o = sum_i;
        end else if (signed_i && is_top_i) begin
            res_o = clamp_hi_i ? S_MAX : S_MIN;
        end else begin
            res_o = clamp_hi_i ? ONES : ZEROS;
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int SEG_W   = 8,
    parameter int NUM_SEG = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid_i,
    input  logic [2:0]                 op_i,
    input  logic [1:0]                 mode_i,
    input  logic [1:0]                 size_i,
    input  logic [SEG_W*NUM_SEG-1:0]   a_i,
    input  logic [SEG_W*NUM_SEG-1:0]   b_i,
    output logic                       out_valid_o,
    output logic [SEG_W*NUM_SEG-1:0]   result_o
);
    localparam int DATA_W = SEG_W * NUM_SEG;
    localparam int IDX_W  = $clog2(NUM_SEG);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
    } out_st_t;

    out_st_t st_d, st_q;

    logic              is_sub;
    logic              sat_active;
    logic              signed_mode;
    logic [IDX_W-1:0]  lane_mask;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] arith_res;
    logic [NUM_SEG-1:0] cin, cout, cmsb, seg_start, sovf, uovf, a_sign;

    always_comb begin
        is_sub      = (op_i == OP_SUB);
        b_eff       = is_sub ? ~b_i : b_i;
        lane_mask   = IDX_W'((4'd1 << size_i) - 4'd1);
        signed_mode = (mode_i == MD_SSAT);
        sat_active  = (op_i == OP_ADD || op_i == OP_SUB)
                   && (size_i == SZ_8 || size_i == SZ_16)
                   && (mode_i == MD_SSAT || mode_i == MD_USAT);
    end

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [IDX_W-1:0] SEG_ID = g;
        logic [SEG_W-1:0] seg_sum;
        logic [IDX_W-1:0] top_idx;
        logic             clamp_en;
        logic             clamp_hi;

        assign seg_start[g] = (SEG_ID & lane_mask) == '0;
        if (g == 0) begin : g_first
            assign cin[g] = is_sub;
        end else begin : g_rest
            assign cin[g] = seg_start[g] ? is_sub : cout[g-1];
        end

        simd_seg_add #(.SEG_W(SEG_W)) u_add (
            .a_i    (a_i[g*SEG_W +: SEG_W]),
            .b_i    (b_eff[g*SEG_W +: SEG_W]),
            .cin_i  (cin[g]),
            .sum_o  (seg_sum),
            .cout_o (cout[g]),
            .cmsb_o (cmsb[g])
        );

        assign sovf[g]   = cmsb[g] ^ cout[g];
        assign uovf[g]   = is_sub ? ~cout[g] : cout[g];
        assign a_sign[g] = a_i[g*SEG_W + SEG_W - 1];

        assign top_idx  = SEG_ID | lane_mask;
        assign clamp_en = sat_active & (signed_mode ? sovf[top_idx] : uovf[top_idx]);
        assign clamp_hi = signed_mode ? ~a_sign[top_idx] : ~is_sub;

        simd_seg_clamp #(.SEG_W(SEG_W)) u_clamp (
            .sum_i      (seg_sum),
            .clamp_en_i (clamp_en),
            .clamp_hi_i (clamp_hi),
            .signed_i   (signed_mode),
            .is_top_i   (top_idx == SEG_ID),
            .res_o      (arith_res[g*SEG_W +: SEG_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            case (op_i)
                OP_ADD, OP_SUB: st_d.res = arith_res;
                OP_AND:         st_d.res = a_i & b_i;
                OP_OR:          st_d.res = a_i | b_i;
                OP_XOR:         st_d.res = a_i ^ b_i;
                OP_ANDN:        st_d.res = a_i & ~b_i;
                default:        st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign result_o    = st_q.res;

    function automatic logic bytes_not_below(input logic [DATA_W-1:0] r,
                                             input logic [DATA_W-1:0] a);
        logic ok = 1'b1;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (r[k*SEG_W +: SEG_W] < a[k*SEG_W +: SEG_W]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic no_sign_flip(input logic [DATA_W-1:0] r,
                                          input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b);
        logic ok = 1'b1;
        for (int k = 0; k < NUM_SEG; k++) begin
            if (!a[k*SEG_W + SEG_W - 1] && !b[k*SEG_W + SEG_W - 1]
                && r[k*SEG_W + SEG_W - 1]) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o == $past(in_valid_i)); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> $stable(result_o)); // R10

    AST_USAT_ADD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_ADD && mode_i == MD_USAT && size_i == SZ_8)
        |=> bytes_not_below(result_o, $past(a_i))); // R6

    AST_SSAT_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_ADD && mode_i == MD_SSAT && size_i == SZ_8)
        |=> no_sign_flip(result_o, $past(a_i), $past(b_i))); // R4

    AST_LOGIC_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_AND)
        |=> result_o == ($past(a_i) & $past(b_i))); // R9

    AST_WRAP_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && op_i == OP_ADD && mode_i == MD_WRAP && size_i == SZ_8)
        |=> result_o[SEG_W-1:0] == SEG_W'($past(a_i[SEG_W-1:0]) + $past(b_i[SEG_W-1:0]))); // R1

endmodule

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [63:0] a = '0, b = '0;
    logic        out_valid;
    logic [63:0] result;

    int errors = 0;
    int checks = 0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R10";

    always #10 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op),
        .mode_i(mode), .size_i(size), .a_i(a), .b_i(b),
        .out_valid_o(out_valid), .result_o(result)
    );

    function automatic logic [63:0] model(input logic [63:0] ma, input logic [63:0] mb,
                                          input logic [2:0] mop, input logic [1:0] mmode,
                                          input logic [1:0] msize);
        int w = 8 << msize;
        logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        logic [63:0] r = '0;
        case (mop)
            3'd2: return ma & mb;
            3'd3: return ma | mb;
            3'd4: return ma ^ mb;
            3'd5: return ma & ~mb;
            3'd0, 3'd1: ;
            default: return '0;
        endcase
        for (int l = 0; l < 64 / w; l++) begin
            logic [63:0] la = (ma >> (l * w)) & mask;
            logic [63:0] lb = (mb >> (l * w)) & mask;
            logic [63:0] lr = ((mop == 3'd0) ? la + lb : la - lb) & mask;
            if (w <= 16 && (mmode == 2'd1 || mmode == 2'd2)) begin
                longint sa = longint'(la);
                longint sb = longint'(lb);
                longint sr, lo, hi;
                if (mmode == 2'd1) begin
                    if (la[w-1]) sa = sa - (longint'(1) << w);
                    if (lb[w-1]) sb = sb - (longint'(1) << w);
                    lo = -(longint'(1) << (w - 1));
                    hi = (longint'(1) << (w - 1)) - 1;
                end else begin
                    lo = 0;
                    hi = (longint'(1) << w) - 1;
                end
                sr = (mop == 3'd0) ? sa + sb : sa - sb;
                if (sr > hi) sr = hi;
                if (sr < lo) sr = lo;
                lr = 64'(sr) & mask;
            end
            r = r | (lr << (l * w));
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] t_op, input logic [1:0] t_mode,
                                     input logic [1:0] t_size);
        if (t_op > 3'd1) return "R9";
        if ((t_mode == 2'd1 || t_mode == 2'd2) && t_size >= 2'd2) return "R8";
        if (t_size == 2'd3) return "R3";
        if (t_mode == 2'd1) return (t_op == 3'd0) ? "R4" : "R5";
        if (t_mode == 2'd2) return (t_op == 3'd0) ? "R6" : "R7";
        return (t_op == 3'd0) ? "R1" : "R2";
    endfunction

    task automatic compare_now();
        checks++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL R10 valid (%s): got %0b expected %0b", exp_tag, out_valid, exp_valid);
        end
        checks++;
        if (result !== exp_res) begin
            errors++;
            $display("FAIL %s result: got %h expected %h", exp_tag, result, exp_res);
        end
    endtask

    task automatic step(input logic v, input logic [63:0] ta, input logic [63:0] tb_,
                        input logic [2:0] top, input logic [1:0] tmode,
                        input logic [1:0] tsize, input string tag);
        @(negedge clk);
        compare_now();
        in_valid = v; a = ta; b = tb_; op = top; mode = tmode; size = tsize;
        exp_valid = v;
        if (v) exp_res = model(ta, tb_, top, tmode, tsize);
        exp_tag = v ? tag : "R10";
    endtask

    initial begin
        #(20 * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state compared on first step
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 3'd0, 2'd0, 2'd0, "R1");
        step(1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd0, 2'd2, "R1");
        step(1, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 3'd1, 2'd0, 2'd1, "R2");
        step(1, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 3'd1, 2'd3, 2'd0, "R2");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd0, 2'd3, "R3");
        step(1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 3'd1, 2'd0, 2'd3, "R3");
        step(1, 64'h7F7F_8080_7F00_1050, 64'h0101_FFFF_7F00_7030, 3'd0, 2'd1, 2'd0, "R4");
        step(1, 64'h7FFF_8000_1234_4000, 64'h0001_FFFF_0001_4000, 3'd0, 2'd1, 2'd1, "R4");
        step(1, 64'h8000_7FFF_0005_C000, 64'h0001_FFFF_0010_4001, 3'd1, 2'd1, 2'd1, "R5");
        step(1, 64'h807F_0102_0304_0506, 64'h01FF_0203_0000_7F06, 3'd1, 2'd1, 2'd0, "R5");
        step(1, 64'hF0FF_0102_8080_0000, 64'h2001_0304_8080_0000, 3'd0, 2'd2, 2'd0, "R6");
        step(1, 64'hFFF0_0001_8000_1234, 64'h0020_FFFF_8000_0001, 3'd0, 2'd2, 2'd1, "R6");
        step(1, 64'h0005_0010_FFFF_0000, 64'h0010_0005_0001_0001, 3'd1, 2'd2, 2'd1, "R7");
        step(1, 64'h0102_0304_0506_0708, 64'h0201_0403_0605_0807, 3'd1, 2'd2, 2'd0, "R7");
        step(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd1, 2'd2, "R8");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 3'd0, 2'd2, 2'd3, "R8");
        step(1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 3'd1, 2'd2, 2'd2, "R8");
        step(1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, 3'd2, 2'd1, 2'd0, "R9");
        step(1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, 3'd3, 2'd2, 2'd1, "R9");
        step(1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, 3'd4, 2'd0, 2'd2, "R9");
        step(1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, 3'd5, 2'd1, 2'd3, "R9");
        step(1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, 3'd6, 2'd0, 2'd0, "R9");
        // R10: idle cycles must hold the previous result
        step(0, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 3'd0, 2'd0, 2'd0, "R10");
        step(0, 64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444, 3'd3, 2'd0, 2'd0, "R10");
        for (int i = 0; i < 600; i++) begin
            logic        v  = ($urandom_range(0, 9) != 0);
            logic [2:0]  ro = 3'($urandom_range(0, 7));
            logic [1:0]  rm = 2'($urandom_range(0, 3));
            logic [1:0]  rs = 2'($urandom_range(0, 3));
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            if (ro > 3'd5 && $urandom_range(0, 3) != 0) ro = 3'($urandom_range(0, 1));
            step(v, ra, rb, ro, rm, rs, tag_of(ro, rm, rs));
        end
        step(0, '0, '0, 3'd0, 2'd0, 2'd0, "R10");
        @(negedge clk);
        compare_now();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule